// File: doc/BRIEF.md
# Periodic SPI Word Scheduler

This block hands 24-bit words to a downstream serial transmitter at a programmable update rate. A 3-bit source select picks where each word comes from: a memory stream, a host data register, a single-channel converter, or one of four converter sample channels. A second memory-stream code drops any word that equals the last one transmitted. This keeps the serial lines quiet while the memory content is not changing. The transmitter is a ready/valid sink, and the scheduler holds each word until the sink accepts it.

A rate counter raises an update strobe once every `div` system clocks. Each stream or converter source is offered one word per strobe. The host path does not use the strobe: it sends the host register once for each trigger pulse. A reload pulse restarts the sequencer. The select code, the rate divider, and the serial clock divider and control word for the shifter are sampled only on that pulse. After reset the select points at the host so that no other source can send stray words.

Top module: `spi_update_sched`

## Requirements
- R1: After the asynchronous reset releases, `tx_valid_o` is 0 and `sclk_div_o` is 0x13. `ctrl_o` is 0x3010, the select is the host code 1 and the rate divider is `DIV_RST`. A memory or converter word therefore produces no output until a reload.
- R2: The select codes are 0 memory stream, 1 host, 2 single-channel converter A, 3 memory stream with repeat suppression, and 4 to 7 converter channels 0 to 3. Converter channel k is read from `conv_data_i[24k +: 24]` and `conv_valid_i[k]`.
- R3: With a sampled divider D, the update strobe fires once every D clocks. The first strobe comes on the D-th clock edge after the reload edge. D = 0 behaves as D = 1, which gives a strobe on every clock.
- R4: For a stream or converter code, a word is issued at a strobe edge only if the selected source's valid and `tx_ready_i` are both high. Otherwise that strobe is lost and nothing is queued. An issued word appears on `tx_data_o` with `tx_valid_o` high after that edge.
- R5: In code 3, a word equal to the last issued word is not issued. The first word after a reset or reload is always issued.
- R6: In host code, each `host_trig_i` pulse sends `host_data_i` once. It goes out at the first edge, from the trigger edge onward, on which `tx_ready_i` is high. Triggers that arrive while one is still pending merge into it. Triggers under any other code are ignored.
- R7: A reload pulse samples the select, both dividers and the control word, which are ignored at all other times. It also clears `tx_valid_o`, any pending host trigger and the suppression history, and restarts the rate counter.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, with no reload, `tx_valid_o` stays high and `tx_data_o` keeps its value. A word is dropped after an edge where `tx_ready_i` is high and nothing new is issued.
- R9: `sclk_div_o` and `ctrl_o` show the values captured at the last reload, or their reset defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_reload_i | input | 1 | Reload pulse: sample configuration, restart sequencer |
| sel_i | input | 3 | Source select code |
| div_i | input | DIV_W | Update period in system clocks |
| sclk_div_i | input | 8 | Serial clock divider for the shifter |
| ctrl_i | input | 16 | Control word for the shifter |
| mem_data_i | input | DATA_W | Memory stream word |
| mem_valid_i | input | 1 | Memory stream word valid |
| host_data_i | input | DATA_W | Host data register |
| host_trig_i | input | 1 | Host send pulse |
| adc_a_data_i | input | DATA_W | Single-channel converter sample |
| adc_a_valid_i | input | 1 | Single-channel converter sample valid |
| conv_data_i | input | N_CONV*DATA_W | Packed converter channel samples |
| conv_valid_i | input | N_CONV | Converter channel valids |
| tx_ready_i | input | 1 | Transmitter ready |
| tx_valid_o | output | 1 | Word valid toward transmitter |
| tx_data_o | output | DATA_W | Word toward transmitter |
| sclk_div_o | output | 8 | Captured serial clock divider |
| ctrl_o | output | 16 | Captured control word |

## Verification
The bench aims at suppression with narrow memory data, so repeats are frequent. If the history is not cleared on reload, the first word after a restart is lost. If the history is updated on words that were never sent, valid duplicates get through. Other targets are host triggers against a busy sink and `sel_i`/`div_i` changing between reloads. A design that drops a pending trigger sends too few words, and one that reads live configuration changes mode or rate mid-run. Dividers of 0 and 1 are checked against an exact word count, which exposes an off-by-one period or a zero divider that stalls the counter.

// File: rtl/spi_sched_pkg.sv
package spi_sched_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned SCLK_W = 8;
  localparam int unsigned CTRL_W = 16;

  typedef enum logic [SEL_W-1:0] {
    SRC_MEM    = 3'd0,
    SRC_HOST   = 3'd1,
    SRC_ADC_A  = 3'd2,
    SRC_MEM_NR = 3'd3,
    SRC_CONV0  = 3'd4,
    SRC_CONV1  = 3'd5,
    SRC_CONV2  = 3'd6,
    SRC_CONV3  = 3'd7
  } src_sel_e;

  localparam logic [SCLK_W-1:0] SCLK_DIV_RST = 8'h13;
  localparam logic [CTRL_W-1:0] CTRL_RST     = 16'h3010;
endpackage

// File: rtl/sched_rate_timer.sv
module sched_rate_timer #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divide value 0 behaves as 1
  assign lim      = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign strobe_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (strobe_o)  cnt_q <= '0;
    else                cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sched_src_mux.sv
module sched_src_mux
  import spi_sched_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned N_CONV = 4
) (
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [DATA_W-1:0]        mem_data_i,
  input  logic                     mem_valid_i,
  input  logic [DATA_W-1:0]        adc_data_i,
  input  logic                     adc_valid_i,
  input  logic [N_CONV*DATA_W-1:0] conv_data_i,
  input  logic [N_CONV-1:0]        conv_valid_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     valid_o,
  output logic                     host_mode_o,
  output logic                     dedup_o
);
  localparam int unsigned IDX_W = $clog2(N_CONV);

  logic [DATA_W-1:0] conv_w [N_CONV];

  for (genvar g = 0; g < N_CONV; g++) begin : g_conv
    assign conv_w[g] = conv_data_i[g*DATA_W +: DATA_W];
  end

  assign host_mode_o = (sel_i == SRC_HOST);
  assign dedup_o     = (sel_i == SRC_MEM_NR);

  always_comb begin
    data_o  = '0;
    valid_o = 1'b0;
    case (sel_i)
      SRC_MEM, SRC_MEM_NR: begin
        data_o  = mem_data_i;
        valid_o = mem_valid_i;
      end
      SRC_ADC_A: begin
        data_o  = adc_data_i;
        valid_o = adc_valid_i;
      end
      SRC_HOST: begin
        data_o  = '0;
        valid_o = 1'b0;
      end
      default: begin
        // codes 4..7: low bits pick the converter channel
        data_o  = conv_w[sel_i[IDX_W-1:0]];
        valid_o = conv_valid_i[sel_i[IDX_W-1:0]];
      end
    endcase
  end
endmodule

// File: rtl/sched_issue_ctrl.sv
module sched_issue_ctrl #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              strobe_i,
  input  logic              host_mode_i,
  input  logic              dedup_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_trig_i,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              host_pend_o
);
  logic              pend_q, first_q, valid_q;
  logic [DATA_W-1:0] last_q, data_q;
  logic              pend_n, dup, stream_go, host_go, issue;
  logic [DATA_W-1:0] issue_data;

  always_comb begin
    pend_n     = pend_q | (host_mode_i & host_trig_i);
    dup        = dedup_i & ~first_q & (src_data_i == last_q);
    stream_go  = ~host_mode_i & strobe_i & src_valid_i & ~dup;
    host_go    = host_mode_i & pend_n;
    issue      = ~restart_i & tx_ready_i & (stream_go | host_go);
    issue_data = host_mode_i ? host_data_i : src_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      first_q <= 1'b1;
      last_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (restart_i) begin
      pend_q  <= 1'b0;
      first_q <= 1'b1;
      last_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      pend_q <= pend_n & ~issue;
      if (issue) begin
        valid_q <= 1'b1;
        data_q  <= issue_data;
        last_q  <= issue_data;
        first_q <= 1'b0;
      end else if (tx_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign tx_data_o   = data_q;
  assign tx_valid_o  = valid_q;
  assign host_pend_o = pend_q;
endmodule

// File: rtl/spi_update_sched.sv
module spi_update_sched
  import spi_sched_pkg::*;
#(
  parameter int unsigned     DATA_W  = 24,
  parameter int unsigned     DIV_W   = 16,
  parameter int unsigned     N_CONV  = 4,
  parameter logic [DIV_W-1:0] DIV_RST = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_reload_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic [SCLK_W-1:0]        sclk_div_i,
  input  logic [CTRL_W-1:0]        ctrl_i,
  input  logic [DATA_W-1:0]        mem_data_i,
  input  logic                     mem_valid_i,
  input  logic [DATA_W-1:0]        host_data_i,
  input  logic                     host_trig_i,
  input  logic [DATA_W-1:0]        adc_a_data_i,
  input  logic                     adc_a_valid_i,
  input  logic [N_CONV*DATA_W-1:0] conv_data_i,
  input  logic [N_CONV-1:0]        conv_valid_i,
  input  logic                     tx_ready_i,
  output logic                     tx_valid_o,
  output logic [DATA_W-1:0]        tx_data_o,
  output logic [SCLK_W-1:0]        sclk_div_o,
  output logic [CTRL_W-1:0]        ctrl_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_W-1:0]  div_q;
  logic [SCLK_W-1:0] sclk_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              strobe, src_valid, host_mode, dedup, host_pend;
  logic [DATA_W-1:0] src_data;

  // configuration is captured only on the reload pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SRC_HOST;
      div_q  <= DIV_RST;
      sclk_q <= SCLK_DIV_RST;
      ctrl_q <= CTRL_RST;
    end else if (cfg_reload_i) begin
      sel_q  <= sel_i;
      div_q  <= div_i;
      sclk_q <= sclk_div_i;
      ctrl_q <= ctrl_i;
    end
  end

  assign sclk_div_o = sclk_q;
  assign ctrl_o     = ctrl_q;

  sched_rate_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(cfg_reload_i),
    .div_i    (div_q),
    .strobe_o (strobe)
  );

  sched_src_mux #(.DATA_W(DATA_W), .N_CONV(N_CONV)) u_mux (
    .sel_i       (sel_q),
    .mem_data_i  (mem_data_i),
    .mem_valid_i (mem_valid_i),
    .adc_data_i  (adc_a_data_i),
    .adc_valid_i (adc_a_valid_i),
    .conv_data_i (conv_data_i),
    .conv_valid_i(conv_valid_i),
    .data_o      (src_data),
    .valid_o     (src_valid),
    .host_mode_o (host_mode),
    .dedup_o     (dedup)
  );

  sched_issue_ctrl #(.DATA_W(DATA_W)) u_issue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (cfg_reload_i),
    .strobe_i   (strobe),
    .host_mode_i(host_mode),
    .dedup_i    (dedup),
    .src_data_i (src_data),
    .src_valid_i(src_valid),
    .host_data_i(host_data_i),
    .host_trig_i(host_trig_i),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .host_pend_o(host_pend)
  );
endmodule

// File: rtl/spi_update_sched_chk.sv
module spi_update_sched_chk
  import spi_sched_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DIV_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_reload_i,
  input logic              host_trig_i,
  input logic              tx_ready_i,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic [SEL_W-1:0]  sel_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              strobe,
  input logic              host_pend
);
  p_rate_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && div_q > DIV_W'(1) && !cfg_reload_i |=> !strobe);

  p_no_repeat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q == SRC_MEM_NR && tx_valid_o && tx_ready_i && !cfg_reload_i
    |=> !tx_valid_o || tx_data_o != $past(tx_data_o));

  p_host_needs_trig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q == SRC_HOST && !host_pend && !host_trig_i && tx_ready_i && !cfg_reload_i
    |=> !tx_valid_o);

  p_reload_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reload_i |=> !tx_valid_o);

  p_hold_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !cfg_reload_i |=> tx_valid_o && $stable(tx_data_o));
endmodule

bind spi_update_sched spi_update_sched_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_reload_i(cfg_reload_i),
  .host_trig_i (host_trig_i),
  .tx_ready_i  (tx_ready_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .sel_q       (sel_q),
  .div_q       (div_q),
  .strobe      (strobe),
  .host_pend   (host_pend)
);

// File: tb/spi_update_sched_bench.sv
`timescale 1ns/1ps
module spi_update_sched_bench;
  localparam int DW = 24;
  localparam int VW = 16;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          cfg_reload_i = 0;
  logic [2:0]    sel_i = 0;
  logic [VW-1:0] div_i = 0;
  logic [7:0]    sclk_div_i = 0;
  logic [15:0]   ctrl_i = 0;
  logic [DW-1:0] mem_data_i = 0, host_data_i = 0, adc_a_data_i = 0;
  logic          mem_valid_i = 0, host_trig_i = 0, adc_a_valid_i = 0;
  logic [4*DW-1:0] conv_data_i = 0;
  logic [3:0]    conv_valid_i = 0;
  logic          tx_ready_i = 0;
  logic          tx_valid_o;
  logic [DW-1:0] tx_data_o;
  logic [7:0]    sclk_div_o;
  logic [15:0]   ctrl_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  logic [2:0]    m_sel;
  logic [VW-1:0] m_div, m_cnt;
  logic [7:0]    m_sclk;
  logic [15:0]   m_ctrl;
  logic          m_pend, m_first, m_valid;
  logic [DW-1:0] m_last, m_data;

  always #5 clk_i = ~clk_i;

  spi_update_sched u_spi_update_sched (.*);

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_sel = 3'd1; m_div = 1; m_sclk = 8'h13; m_ctrl = 16'h3010;
    m_cnt = 0; m_pend = 0; m_first = 1; m_valid = 0; m_last = 0; m_data = 0;
  endfunction

  function automatic void model_step();
    logic [VW-1:0] lim;
    logic strb, host, sv, pn, dup, go;
    logic [DW-1:0] sd, d;
    lim  = (m_div == 0) ? 0 : m_div - 1;
    strb = (m_cnt == lim);
    if (cfg_reload_i) begin
      m_sel = sel_i; m_div = div_i; m_sclk = sclk_div_i; m_ctrl = ctrl_i;
      m_cnt = 0; m_pend = 0; m_first = 1; m_last = 0; m_valid = 0;
      return;
    end
    host = (m_sel == 3'd1);
    case (m_sel)
      3'd0, 3'd3: begin sd = mem_data_i; sv = mem_valid_i; end
      3'd2:       begin sd = adc_a_data_i; sv = adc_a_valid_i; end
      3'd1:       begin sd = 0; sv = 0; end
      default:    begin sd = conv_data_i[m_sel[1:0]*DW +: DW]; sv = conv_valid_i[m_sel[1:0]]; end
    endcase
    pn  = m_pend | (host & host_trig_i);
    dup = (m_sel == 3'd3) && !m_first && (sd == m_last);
    go  = tx_ready_i && (host ? pn : (strb && sv && !dup));
    d   = host ? host_data_i : sd;
    if (go) begin m_valid = 1; m_data = d; m_last = d; m_first = 0; end
    else if (tx_ready_i) m_valid = 0;
    m_pend = pn & !go;
    m_cnt  = strb ? 0 : m_cnt + 1;
  endfunction

  function automatic string mode_tag();
    case (m_sel)
      3'd1:    return "R6";
      3'd3:    return "R5";
      3'd0:    return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic compare(string t);
    chk(t, 32'(tx_valid_o), 32'(m_valid));
    if (m_valid) chk(t, 32'(tx_data_o), 32'(m_data));
    chk("R9", {sclk_div_o, 8'h0, ctrl_o}, {m_sclk, 8'h0, m_ctrl});
  endtask

  // one clock: model follows the edge, outputs checked mid-cycle
  task automatic step(string t);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare(t);
  endtask

  task automatic reload(logic [2:0] s, logic [VW-1:0] dv);
    cfg_reload_i = 1; sel_i = s; div_i = dv;
    sclk_div_i = 8'($urandom); ctrl_i = 16'($urandom);
    step("R7");
    cfg_reload_i = 0;
  endtask

  task automatic count_words(logic [VW-1:0] dv, int exp_n);
    int n = 0;
    mem_valid_i = 1; tx_ready_i = 1;
    reload(3'd0, dv);
    for (int i = 0; i < 30; i++) begin
      mem_data_i = DW'(i);
      div_i = VW'($urandom % 7);
      step("R3");
      if (tx_valid_o) n++;
    end
    chk("R3", 32'(n), 32'(exp_n));
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    chk("R1", 32'(tx_valid_o), 32'd0);
    chk("R1", {sclk_div_o, ctrl_o}, {8'h13, 16'h3010});
    // host default: streaming sources send nothing
    mem_valid_i = 1; adc_a_valid_i = 1; conv_valid_i = 4'hf; tx_ready_i = 1;
    for (int i = 0; i < 10; i++) begin mem_data_i = DW'(i); step("R1"); end
    // host trigger after reset
    host_data_i = 24'hABCDEF; host_trig_i = 1; step("R6");
    host_trig_i = 0; step("R6");

    // exact period counts
    count_words(3, 10);
    count_words(0, 30);
    count_words(1, 30);

    // repeat suppression with a constant word
    mem_data_i = 24'h55AA55; mem_valid_i = 1; tx_ready_i = 1;
    reload(3'd3, 1);
    for (int i = 0; i < 6; i++) step("R5");
    reload(3'd3, 1);
    step("R5");
    chk("R5", 32'(tx_valid_o), 32'd1);

    // hold while sink busy, host triggers merge while pending
    reload(3'd1, 2);
    tx_ready_i = 0; host_data_i = 24'h123456; host_trig_i = 1; step("R8");
    host_trig_i = 0;
    for (int i = 0; i < 4; i++) begin host_trig_i = (i == 1); step("R8"); end
    host_trig_i = 0; tx_ready_i = 1;
    for (int i = 0; i < 4; i++) step("R6");

    // triggers ignored outside host mode
    reload(3'd5, 2); mem_valid_i = 0; conv_valid_i = 0;
    for (int i = 0; i < 6; i++) begin host_trig_i = 1; step("R6"); end
    host_trig_i = 0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) begin
        reload(3'($urandom), VW'($urandom % 5));
      end else begin
        sel_i = 3'($urandom); div_i = VW'($urandom);
        sclk_div_i = 8'($urandom); ctrl_i = 16'($urandom);
        mem_data_i = DW'($urandom % 3); mem_valid_i = ($urandom % 10) < 7;
        adc_a_data_i = DW'($urandom); adc_a_valid_i = ($urandom % 10) < 7;
        conv_data_i = {$urandom, $urandom, $urandom};
        conv_valid_i = 4'($urandom);
        host_data_i = DW'($urandom); host_trig_i = ($urandom % 5) == 0;
        tx_ready_i = ($urandom % 4) != 0;
        step(mode_tag());
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule